// File: doc/BRIEF.md
# Locality-Based Register Access Arbiter

This block sits between a bus front end and a register file that is shared by up to five software localities. Each cycle the front end may present one decoded access: the requesting locality number, a register class code and a read/write flag. In the same cycle the arbiter answers with exactly one of two outcomes. `done` means the register file may perform the access. `abort` means the front end must withhold its acknowledge handshake and drop the access. The answer depends on the register class and on how the requester relates to the current owner: it may be the active locality, another locality may be active, or no locality may be active.

The arbiter also holds the ownership state. That state is a valid bit plus a locality number. It changes only through accepted writes:
- access-register writes carry a claim flag and a release flag;
- a hash-start write seizes ownership for locality 4;
- a hash-end write gives locality 4's ownership back.

An accepted interrupt-status write from the owner produces a one-cycle clear pulse for the interrupt logic. The gating of data-buffer reads uses a data-available flag that comes from the buffer.

Top module: `lac_arbiter`

## Requirements
- R1: Class code 0 (status) is performed for reads and writes only when the requester is the active locality; every other status access aborts.
- R2: Class codes 1 (interrupt enable), 2 (interrupt vector) and 7 (configuration) are read by any locality in any ownership state, and are written only by the active locality; other writes abort.
- R3: Class code 3 (interrupt status) is readable by anyone. A write from the active locality is performed and raises `int_clr` in the same cycle. A write from any other locality aborts with `int_clr` low.
- R4: Class code 4 (interrupt capability) is readable by anyone; every write to it aborts.
- R5: Class code 5 (access) is performed for reads and writes from any in-range locality in every ownership state.
- R6: Class code 6 (data buffer) reads are performed only for the active locality while `fifo_avail` is 1. Its writes are performed only for the active locality. All other data-buffer accesses abort.
- R7: Class code 8 (hash start) writes are performed only while no locality is active. The next cycle shows `act_valid`=1 and `act_loc`=4. Reads of it abort.
- R8: Class codes 9 (hash data) and 10 (hash end) writes are performed only for the active locality, and reads of them abort. An accepted hash-end write leaves no locality active on the next cycle.
- R9: An accepted access-register write with `wr_release`=1 from the active locality leaves no locality active. With `wr_claim`=1 while none is active, it makes the requester active. A claim while another locality is active, or a release from a non-owner, leaves the state unchanged. Release takes precedence over claim.
- R10: The decision is combinational in the request cycle, with `done` and `abort` never both high. Ownership changes appear at the next clock edge, and an aborted access changes no state.
- R11: After reset no locality is active (`act_valid`=0, `act_loc`=0).
- R12: A requester locality of 5 or above, and class codes 11 to 15, always abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A decoded access is present this cycle |
| req_loc | input | 3 | Requesting locality number |
| req_cls | input | 4 | Register class code |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_claim | input | 1 | Access-register write data: request ownership |
| wr_release | input | 1 | Access-register write data: give up ownership |
| fifo_avail | input | 1 | Data buffer holds readable data |
| done | output | 1 | Access is performed |
| abort | output | 1 | Access is dropped; no acknowledge |
| int_clr | output | 1 | Pulse clearing the pending interrupt |
| act_valid | output | 1 | A locality currently owns the block |
| act_loc | output | 3 | Number of the owning locality |

## Verification
A corrupted ownership register shows up first on `act_valid` and `act_loc` at the very next edge. Its effects then follow in later cycles: a status or data-buffer access from the true owner aborts, or one from an intruder is performed. A wrong permission entry affects only its class and direction, and it flips `done` against `abort` in the request cycle itself. For that reason each class is driven from the owner, from a non-owner and with no owner. A side effect fired on an aborted write appears one cycle later as an ownership change that should not have happened.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int CLS_W   = 4;
  localparam int NUM_CLS = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_STS    = 4'd0,
    CLS_INTEN  = 4'd1,
    CLS_INTVEC = 4'd2,
    CLS_INTSTS = 4'd3,
    CLS_INTCAP = 4'd4,
    CLS_ACCESS = 4'd5,
    CLS_FIFO   = 4'd6,
    CLS_CFG    = 4'd7,
    CLS_HSTART = 4'd8,
    CLS_HDATA  = 4'd9,
    CLS_HEND   = 4'd10
  } reg_cls_e;

  typedef enum logic [1:0] {
    REL_NONE  = 2'd0,
    REL_OWN   = 2'd1,
    REL_OTHER = 2'd2
  } rel_e;

  // Permission of one class for one direction and relation.
  function automatic logic permits(logic [CLS_W-1:0] c, logic wr, rel_e r, logic avail);
    logic own;
    own = (r == REL_OWN);
    case (c)
      CLS_STS:                       permits = own;
      CLS_INTEN, CLS_INTVEC, CLS_CFG,
      CLS_INTSTS:                    permits = wr ? own : 1'b1;
      CLS_INTCAP:                    permits = !wr;
      CLS_ACCESS:                    permits = 1'b1;
      CLS_FIFO:                      permits = wr ? own : (own && avail);
      CLS_HSTART:                    permits = wr && (r == REL_NONE);
      CLS_HDATA, CLS_HEND:           permits = wr && own;
      default:                       permits = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lac_relate.sv
module lac_relate
  import lac_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic             act_valid,
  input  logic [LOC_W-1:0] act_loc,
  input  logic [LOC_W-1:0] req_loc,
  output rel_e             rel,
  output logic             loc_ok
);
  assign loc_ok = (int'(req_loc) < NUM_LOC);

  always_comb begin
    if (!act_valid)              rel = REL_NONE;
    else if (act_loc == req_loc) rel = REL_OWN;
    else                         rel = REL_OTHER;
  end
endmodule

// File: rtl/lac_matrix.sv
module lac_matrix
  import lac_pkg::*;
(
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_cls,
  input  logic             req_write,
  input  rel_e             rel,
  input  logic             loc_ok,
  input  logic             fifo_avail,
  output logic             perm_ok,
  output logic             done,
  output logic             abort,
  output logic             int_clr
);
  logic [NUM_CLS-1:0] perm_vec;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    assign perm_vec[g] = permits(CLS_W'(g), req_write, rel, fifo_avail);
  end

  assign perm_ok = loc_ok && perm_vec[req_cls];
  assign done    = req_valid && perm_ok;
  assign abort   = req_valid && !perm_ok;
  assign int_clr = done && req_write && (req_cls == CLS_INTSTS);
endmodule

// File: rtl/lac_state.sv
module lac_state
  import lac_pkg::*;
#(
  parameter int LOC_W    = 3,
  parameter int HASH_LOC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             req_write,
  input  logic [CLS_W-1:0] req_cls,
  input  logic [LOC_W-1:0] req_loc,
  input  rel_e             rel,
  input  logic             wr_claim,
  input  logic             wr_release,
  output logic             act_valid,
  output logic [LOC_W-1:0] act_loc,
  output logic             ev_claim,
  output logic             ev_release,
  output logic             ev_hash_grab,
  output logic             ev_hash_drop
);
  logic wr_done;
  logic acc_wr;

  assign wr_done      = done && req_write;
  assign acc_wr       = wr_done && (req_cls == CLS_ACCESS);
  assign ev_hash_grab = wr_done && (req_cls == CLS_HSTART);
  assign ev_hash_drop = wr_done && (req_cls == CLS_HEND);
  assign ev_release   = acc_wr && wr_release && (rel == REL_OWN);
  assign ev_claim     = acc_wr && wr_claim && (rel == REL_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_loc   <= '0;
    end else if (ev_hash_grab) begin
      act_valid <= 1'b1;
      act_loc   <= LOC_W'(HASH_LOC);
    end else if (ev_hash_drop || ev_release) begin
      act_valid <= 1'b0;
      act_loc   <= '0;
    end else if (ev_claim) begin
      act_valid <= 1'b1;
      act_loc   <= req_loc;
    end
  end
endmodule

// File: rtl/lac_arbiter.sv
module lac_arbiter
  import lac_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int LOC_W    = 3,
  parameter int HASH_LOC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LOC_W-1:0] req_loc,
  input  logic [CLS_W-1:0] req_cls,
  input  logic             req_write,
  input  logic             wr_claim,
  input  logic             wr_release,
  input  logic             fifo_avail,
  output logic             done,
  output logic             abort,
  output logic             int_clr,
  output logic             act_valid,
  output logic [LOC_W-1:0] act_loc
);
  rel_e rel;
  logic loc_ok;
  logic perm_ok;
  logic ev_claim, ev_release, ev_hash_grab, ev_hash_drop;

  lac_relate #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_relate (
    .act_valid(act_valid), .act_loc(act_loc), .req_loc(req_loc),
    .rel(rel), .loc_ok(loc_ok)
  );

  lac_matrix u_matrix (
    .req_valid(req_valid), .req_cls(req_cls), .req_write(req_write),
    .rel(rel), .loc_ok(loc_ok), .fifo_avail(fifo_avail),
    .perm_ok(perm_ok), .done(done), .abort(abort), .int_clr(int_clr)
  );

  lac_state #(.LOC_W(LOC_W), .HASH_LOC(HASH_LOC)) u_state (
    .clk(clk), .rst_n(rst_n), .done(done), .req_write(req_write),
    .req_cls(req_cls), .req_loc(req_loc), .rel(rel),
    .wr_claim(wr_claim), .wr_release(wr_release),
    .act_valid(act_valid), .act_loc(act_loc),
    .ev_claim(ev_claim), .ev_release(ev_release),
    .ev_hash_grab(ev_hash_grab), .ev_hash_drop(ev_hash_drop)
  );
endmodule

// File: rtl/lac_arbiter_chk.sv
module lac_arbiter_chk
  import lac_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int LOC_W    = 3,
  parameter int HASH_LOC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LOC_W-1:0] req_loc,
  input logic [CLS_W-1:0] req_cls,
  input logic             req_write,
  input logic             fifo_avail,
  input logic             done,
  input logic             abort,
  input logic             int_clr,
  input logic             act_valid,
  input logic [LOC_W-1:0] act_loc,
  input logic             ev_claim,
  input logic             ev_release,
  input logic             ev_hash_grab,
  input logic             ev_hash_drop
);
  logic owner;
  assign owner = act_valid && (act_loc == req_loc);

  AST_STS_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cls == CLS_STS && !owner) |-> abort); // R1
  AST_CFG_WR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_cls == CLS_CFG && !owner) |-> abort); // R2
  AST_INTCLR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |-> (owner && req_write && done)); // R3
  AST_CAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_cls == CLS_INTCAP) |-> abort); // R4
  AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cls == CLS_ACCESS && int'(req_loc) < NUM_LOC) |-> done); // R5
  AST_FIFO_RD_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_cls == CLS_FIFO && !req_write) |-> (fifo_avail && owner)); // R6
  AST_HSTART_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hash_grab |=> (act_valid && act_loc == LOC_W'(HASH_LOC))); // R7
  AST_HEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hash_drop |=> !act_valid); // R8
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_release && !ev_hash_grab) |=> !act_valid); // R9
  AST_CLAIM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_claim |-> !act_valid); // R9
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ($stable(act_valid) && $stable(act_loc))); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abort})); // R10
  AST_BAD_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_loc) >= NUM_LOC) |-> abort); // R12
endmodule

bind lac_arbiter lac_arbiter_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .HASH_LOC(HASH_LOC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_loc(req_loc),
  .req_cls(req_cls), .req_write(req_write), .fifo_avail(fifo_avail),
  .done(done), .abort(abort), .int_clr(int_clr),
  .act_valid(act_valid), .act_loc(act_loc),
  .ev_claim(ev_claim), .ev_release(ev_release),
  .ev_hash_grab(ev_hash_grab), .ev_hash_drop(ev_hash_drop)
);

// File: tb/lac_arbiter_test.sv
module lac_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_loc = '0;
  logic [3:0] req_cls = '0;
  logic       req_write = 1'b0;
  logic       wr_claim = 1'b0;
  logic       wr_release = 1'b0;
  logic       fifo_avail = 1'b0;
  logic       done, abort, int_clr, act_valid;
  logic [2:0] act_loc;

  int n_cmp = 0;
  int n_bad = 0;

  lac_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_loc(req_loc),
    .req_cls(req_cls), .req_write(req_write), .wr_claim(wr_claim),
    .wr_release(wr_release), .fifo_avail(fifo_avail), .done(done),
    .abort(abort), .int_clr(int_clr), .act_valid(act_valid), .act_loc(act_loc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One access: decision checked in its cycle, then the edge is taken.
  task automatic acc(input string tag, input int loc, input int cls, input bit wr,
                     input bit clm, input bit rls, input bit av,
                     input bit exp_done, input bit exp_clr);
    @(negedge clk);
    req_valid = 1'b1; req_loc = 3'(loc); req_cls = 4'(cls); req_write = wr;
    wr_claim = clm; wr_release = rls; fifo_avail = av;
    #1;
    cmp({tag, " done"}, int'(done), int'(exp_done));
    cmp({tag, " abort"}, int'(abort), int'(!exp_done));
    cmp({tag, " int_clr"}, int'(int_clr), int'(exp_clr));
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0; wr_claim = 1'b0; wr_release = 1'b0;
  endtask

  task automatic st(input string tag, input bit v, input int l);
    cmp({tag, " act_valid"}, int'(act_valid), int'(v));
    if (v) cmp({tag, " act_loc"}, int'(act_loc), l);
  endtask

  task automatic claim(input int l);
    acc("claim setup R9", l, 5, 1, 1, 0, 0, 1, 0);
  endtask
  task automatic release_own(input int l);
    acc("release setup R9", l, 5, 1, 0, 1, 0, 1, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    st("R11 reset", 0, 0);
    cmp("R11 reset act_loc", int'(act_loc), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_status;
    acc("R1 sts read none", 0, 0, 0, 0, 0, 0, 0, 0);
    claim(2);
    st("R9 claim loc2", 1, 2);
    acc("R1 sts read own", 2, 0, 0, 0, 0, 0, 1, 0);
    acc("R1 sts write own", 2, 0, 1, 0, 0, 0, 1, 0);
    acc("R1 sts read other", 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R1 sts write other", 1, 0, 1, 0, 0, 0, 0, 0);
    st("R10 after aborts", 1, 2);
  endtask

  task automatic t_intregs;
    acc("R2 inten read other", 0, 1, 0, 0, 0, 0, 1, 0);
    acc("R2 intvec write other", 0, 2, 1, 0, 0, 0, 0, 0);
    acc("R2 cfg write own", 2, 7, 1, 0, 0, 0, 1, 0);
    release_own(2);
    st("R9 release loc2", 0, 0);
    acc("R2 cfg read none", 3, 7, 0, 0, 0, 0, 1, 0);
    acc("R2 inten write none", 3, 1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_intsts;
    acc("R3 intsts read none", 1, 3, 0, 0, 0, 0, 1, 0);
    acc("R3 intsts write none", 1, 3, 1, 0, 0, 0, 0, 0);
    claim(1);
    acc("R3 intsts write own", 1, 3, 1, 0, 0, 0, 1, 1);
    acc("R3 intsts write other", 0, 3, 1, 0, 0, 0, 0, 0);
    acc("R3 intsts read other", 0, 3, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_cap;
    acc("R4 cap write own", 1, 4, 1, 0, 0, 0, 0, 0);
    acc("R4 cap read other", 0, 4, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_access;
    acc("R5 access claim other", 3, 5, 1, 1, 0, 0, 1, 0);
    st("R9 claim while owned", 1, 1);
    acc("R5 access release other", 3, 5, 1, 0, 1, 0, 1, 0);
    st("R9 release by non-owner", 1, 1);
    acc("R5 access read other", 4, 5, 0, 0, 0, 0, 1, 0);
    acc("R9 claim+release own", 1, 5, 1, 1, 1, 0, 1, 0);
    st("R9 release wins", 0, 0);
    acc("R5 access read none", 2, 5, 0, 0, 0, 0, 1, 0);
    claim(4);
    st("R9 claim loc4", 1, 4);
    release_own(4);
    st("R9 release loc4", 0, 0);
  endtask

  task automatic t_fifo;
    acc("R6 fifo read none", 0, 6, 0, 0, 0, 1, 0, 0);
    claim(0);
    acc("R6 fifo read own empty", 0, 6, 0, 0, 0, 0, 0, 0);
    acc("R6 fifo read own avail", 0, 6, 0, 0, 0, 1, 1, 0);
    acc("R6 fifo read other avail", 2, 6, 0, 0, 0, 1, 0, 0);
    acc("R6 fifo write own", 0, 6, 1, 0, 0, 0, 1, 0);
    acc("R6 fifo write other", 2, 6, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_hash;
    acc("R7 hstart write while owned", 0, 8, 1, 0, 0, 0, 0, 0);
    st("R10 aborted hstart keeps owner", 1, 0);
    release_own(0);
    acc("R8 hdata write none", 3, 9, 1, 0, 0, 0, 0, 0);
    acc("R7 hstart read none", 0, 8, 0, 0, 0, 0, 0, 0);
    acc("R7 hstart write none", 0, 8, 1, 0, 0, 0, 1, 0);
    st("R7 hstart grabs loc4", 1, 4);
    acc("R7 hstart write again", 4, 8, 1, 0, 0, 0, 0, 0);
    acc("R8 hdata write own", 4, 9, 1, 0, 0, 0, 1, 0);
    acc("R8 hdata read own", 4, 9, 0, 0, 0, 0, 0, 0);
    acc("R8 hdata write other", 0, 9, 1, 0, 0, 0, 0, 0);
    acc("R8 hend read own", 4, 10, 0, 0, 0, 0, 0, 0);
    acc("R8 hend write other", 0, 10, 1, 0, 0, 0, 0, 0);
    st("R10 aborted hend keeps loc4", 1, 4);
    acc("R8 hend write own", 4, 10, 1, 0, 0, 0, 1, 0);
    st("R8 hend releases", 0, 0);
  endtask

  task automatic t_bad;
    acc("R12 loc5 access claim", 5, 5, 1, 1, 0, 0, 0, 0);
    st("R12 loc5 claim no effect", 0, 0);
    acc("R12 loc7 cfg read", 7, 7, 0, 0, 0, 0, 0, 0);
    claim(3);
    acc("R12 class11 read own", 3, 11, 0, 0, 0, 0, 0, 0);
    acc("R12 class15 write own", 3, 15, 1, 0, 0, 0, 0, 0);
    st("R10 state after bad codes", 1, 3);
  endtask

  initial begin
    t_reset();
    t_status();
    t_intregs();
    t_intsts();
    t_cap();
    t_access();
    t_fifo();
    t_hash();
    t_bad();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule